// File: doc/BRIEF.md
# Fully Associative Page Translation Cache

This block keeps the most recent page translations so that a requester can turn a 32-bit virtual address into a 32-bit physical address without consulting the page table. The address splits into a 20-bit page number in bits 31:12 and a 12-bit byte offset in bits 11:0. The page number is compared with the tag of all 64 entries at once. On a hit, the stored 20-bit physical page number is joined with the unchanged offset. Each entry also holds read and write permissions, a dirty flag and a reference flag.

A lookup that finds no valid entry stalls the requester and raises a walk request carrying the missing page number. An external page-table walker answers with a physical page number and its permissions. The block then writes that translation into a victim slot. In the cycle after the refill, it reports what the victim slot held before, so that logic outside the block can write back a dirty page. A global flush input drops every translation in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: An accepted request whose page number matches the tag of a valid entry, with the access permitted, gives rsp_valid=1 and rsp_hit=1 one clock later, with rsp_paddr = {stored physical page, vaddr[11:0]}.
- R2: After reset no entry is valid, so the first lookup of any page misses and its refill reports a victim that was not valid.
- R3: A miss gives rsp_miss=1 one clock after the request. From the same edge, walk_req=1 and req_ready=0, and walk_vpn holds the missing page number. This lasts until a clock edge with fill_valid=1. Requests offered while walk_req is high are ignored and produce no response.
- R4: A read needs the read permission and a write needs the write permission. A hit without the needed permission gives rsp_fault=1, rsp_hit=0 and rsp_paddr=0, and does not set the dirty flag.
- R5: A permitted write hit sets the entry's dirty flag. Reads never set it. The flag is reported when the entry is later evicted.
- R6: On refill, the victim is the lowest-numbered invalid entry, if any entry is invalid.
- R7: If all entries are valid, the victim is the lowest-numbered entry whose reference flag is clear. If every reference flag is set, all of them are cleared and entry 0 becomes the victim.
- R8: Every hit sets the entry's reference flag, whether or not the access is permitted. A refilled entry starts with its reference flag set and its dirty flag clear.
- R9: One clock after the refill edge, evict_valid pulses high for exactly one cycle. At that time evict_was_valid, evict_dirty and evict_vpn give the victim's state from before it was overwritten.
- R10: A cycle with flush=1 invalidates all entries at the next edge, so any later lookup misses.
- R11: During and just after reset: req_ready=1, walk_req=0, rsp_valid=0 and evict_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | Registered result of the accepted lookup |
| rsp_hit | output | 1 | Permitted hit; rsp_paddr is valid |
| rsp_fault | output | 1 | Hit without the needed permission |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_paddr | output | 32 | Translated physical address |
| walk_req | output | 1 | Translation needed from the page-table walker |
| walk_vpn | output | 20 | Page number to be walked |
| fill_valid | input | 1 | Walker result present |
| fill_ppn | input | 20 | Physical page number from the walker |
| fill_rd | input | 1 | Read permission of the new page |
| fill_wr | input | 1 | Write permission of the new page |
| flush | input | 1 | Invalidate every entry |
| evict_valid | output | 1 | One-cycle pulse after a refill |
| evict_was_valid | output | 1 | The victim held a translation |
| evict_dirty | output | 1 | The victim's page was written |
| evict_vpn | output | 20 | The victim's former page number |

## Verification
The embedded assertions check several properties on every cycle. At most one tag matches. A waiting miss keeps its page number and drops requests until the fill arrives. A fault never carries an address. The eviction pulse lasts exactly one cycle. A permitted write hit leaves the entry dirty. A refilled slot comes up valid, clean and referenced. A flush leaves no valid entry. Whenever a free slot exists, the selected victim is one of them.

Some behaviours can only be shown by the bench's scenarios. These are the exact order in which victims are chosen once the cache is full, the effect of earlier hits on that order, the dirty state seen at eviction, and offset passthrough across many offsets. The bench checks them against a model of all 64 entries.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
  } xc_perm_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } xc_state_e;

endpackage

// File: rtl/xc_entry_array.sv
module xc_entry_array
  import xc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VPN_W-1:0]   lookup_vpn,
  output logic [ENTRIES-1:0] match_vec,
  output logic [PPN_W-1:0]   hit_ppn,
  output xc_perm_t           hit_perm,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] ref_vec,
  input  logic               touch_en,
  input  logic               touch_dirty,
  input  logic               flush,
  input  logic               ref_clr_all,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  xc_perm_t           fill_perm,
  input  logic [IDX_W-1:0]   vic_idx,
  output logic               vic_valid,
  output logic               vic_dirty,
  output logic [VPN_W-1:0]   vic_vpn
);

  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [ENTRIES-1:0] dirty_q, dirty_d;
  logic [ENTRIES-1:0] ref_q,   ref_d;
  logic [ENTRIES-1:0] load_vec;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  xc_perm_t           perm_q [ENTRIES];

  // Tag compare, one comparator per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (tag_q[g] == lookup_vpn);
    assign load_vec[g]  = fill_en && (fill_idx == IDX_W'(g));
  end

  // Hit data: OR-reduction across the (one-hot) match vector.
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_ppn  = hit_ppn  | ({PPN_W{match_vec[i]}} & ppn_q[i]);
      hit_perm = hit_perm | ({2{match_vec[i]}} & perm_q[i]);
    end
  end

  // Next-state of the status flags.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      valid_d[i] = flush ? 1'b0 : valid_q[i];
      ref_d[i]   = ref_clr_all ? 1'b0 : ref_q[i];
      dirty_d[i] = dirty_q[i];
      if (touch_en && match_vec[i]) begin
        ref_d[i] = 1'b1;
        if (touch_dirty) dirty_d[i] = 1'b1;
      end
      if (load_vec[i]) begin
        valid_d[i] = 1'b1;
        ref_d[i]   = 1'b1;
        dirty_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      ref_q   <= ref_d;
    end
  end

  // Payload storage: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (load_vec[i]) begin
        tag_q[i]  <= fill_vpn;
        ppn_q[i]  <= fill_ppn;
        perm_q[i] <= fill_perm;
      end
    end
  end

  assign valid_vec = valid_q;
  assign ref_vec   = ref_q;
  assign vic_valid = valid_q[vic_idx];
  assign vic_dirty = dirty_q[vic_idx];
  assign vic_vpn   = tag_q[vic_idx];

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R1

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !fill_en |=> valid_q == '0); // R10

  AST_FILL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && ref_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]); // R8

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_DIRTY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en && touch_dirty && match_vec[g] && !load_vec[g] |=> dirty_q[g]); // R5
  end

endmodule

// File: rtl/xc_victim_sel.sv
module xc_victim_sel #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ref_vec,
  output logic [IDX_W-1:0]   vic_idx,
  output logic               need_clear
);

  logic             any_inv, any_clr;
  logic [IDX_W-1:0] inv_idx, clr_idx;

  // Scan from the top so that the lowest index is the last one written.
  always_comb begin
    any_inv = 1'b0;
    any_clr = 1'b0;
    inv_idx = '0;
    clr_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_inv = 1'b1;
        inv_idx = IDX_W'(i);
      end
      if (!ref_vec[i]) begin
        any_clr = 1'b1;
        clr_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    need_clear = 1'b0;
    if (any_inv) begin
      vic_idx = inv_idx;
    end else if (any_clr) begin
      vic_idx = clr_idx;
    end else begin
      vic_idx    = '0;
      need_clear = 1'b1;
    end
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != '1) |-> !valid_vec[vic_idx]); // R6

  AST_CLEAR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    need_clear |-> (valid_vec == '1) && (ref_vec == '1)); // R7

endmodule

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 20,
  parameter int VPN_W = VA_W - OFF_W,
  parameter int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  input  logic             hit,
  input  logic [PPN_W-1:0] hit_ppn,
  input  xc_perm_t         hit_perm,
  input  logic             fill_valid,
  output logic             fill_en,
  output logic             touch_en,
  output logic             touch_dirty,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_fault,
  output logic             rsp_miss,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             walk_req,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             vic_valid,
  input  logic             vic_dirty,
  input  logic [VPN_W-1:0] vic_vpn,
  output logic             evict_valid,
  output logic             evict_was_valid,
  output logic             evict_dirty,
  output logic [VPN_W-1:0] evict_vpn
);

  xc_state_e        state_q, state_d;
  logic             accept, permit, grant;
  logic             rsp_valid_q, rsp_hit_q, rsp_fault_q, rsp_miss_q;
  logic [PA_W-1:0]  rsp_paddr_q, rsp_paddr_d;
  logic [VPN_W-1:0] walk_vpn_q;
  logic             evict_valid_q, evict_was_valid_q, evict_dirty_q;
  logic [VPN_W-1:0] evict_vpn_q;

  always_comb begin
    accept      = req_valid && (state_q == ST_IDLE);
    permit      = req_write ? hit_perm.wr : hit_perm.rd;
    grant       = accept && hit && permit;
    fill_en     = fill_valid && (state_q == ST_WAIT);
    touch_en    = accept && hit;
    touch_dirty = grant && req_write;
    rsp_paddr_d = grant ? {hit_ppn, req_vaddr[OFF_W-1:0]} : '0;
    state_d     = state_q;
    case (state_q)
      ST_IDLE: if (accept && !hit) state_d = ST_WAIT;
      ST_WAIT: if (fill_valid)     state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      rsp_valid_q   <= 1'b0;
      rsp_hit_q     <= 1'b0;
      rsp_fault_q   <= 1'b0;
      rsp_miss_q    <= 1'b0;
      rsp_paddr_q   <= '0;
      evict_valid_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      rsp_valid_q   <= accept;
      rsp_hit_q     <= grant;
      rsp_fault_q   <= accept && hit && !permit;
      rsp_miss_q    <= accept && !hit;
      rsp_paddr_q   <= rsp_paddr_d;
      evict_valid_q <= fill_en;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !hit) walk_vpn_q <= req_vaddr[VA_W-1:OFF_W];
    if (fill_en) begin
      evict_was_valid_q <= vic_valid;
      evict_dirty_q     <= vic_dirty;
      evict_vpn_q       <= vic_vpn;
    end
  end

  assign req_ready       = (state_q == ST_IDLE);
  assign walk_req        = (state_q == ST_WAIT);
  assign walk_vpn        = walk_vpn_q;
  assign rsp_valid       = rsp_valid_q;
  assign rsp_hit         = rsp_hit_q;
  assign rsp_fault       = rsp_fault_q;
  assign rsp_miss        = rsp_miss_q;
  assign rsp_paddr       = rsp_paddr_q;
  assign evict_valid     = evict_valid_q;
  assign evict_was_valid = evict_was_valid_q;
  assign evict_dirty     = evict_dirty_q;
  assign evict_vpn       = evict_vpn_q;

  AST_MISS_TO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q && rsp_miss_q |-> walk_req && !req_ready); // R3

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !fill_valid |=> walk_req && $stable(walk_vpn_q)); // R3

  AST_WAIT_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |=> !rsp_valid_q); // R3

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_q |-> !rsp_hit_q && !rsp_miss_q && (rsp_paddr_q == '0)); // R4

  AST_EVICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid_q |=> !evict_valid_q); // R9

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic                   rsp_fault,
  output logic                   rsp_miss,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  output logic                   walk_req,
  output logic [VA_W-OFF_W-1:0]  walk_vpn,
  input  logic                   fill_valid,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  input  logic                   flush,
  output logic                   evict_valid,
  output logic                   evict_was_valid,
  output logic                   evict_dirty,
  output logic [VA_W-OFF_W-1:0]  evict_vpn
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] match_vec, valid_vec, ref_vec;
  logic [PPN_W-1:0]   hit_ppn;
  xc_perm_t           hit_perm, fill_perm;
  logic               touch_en, touch_dirty, fill_en, need_clear;
  logic [IDX_W-1:0]   vic_idx;
  logic               vic_valid, vic_dirty;
  logic [VPN_W-1:0]   vic_vpn;

  assign fill_perm = '{rd: fill_rd, wr: fill_wr};

  xc_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookup_vpn  (req_vaddr[VA_W-1:OFF_W]),
    .match_vec   (match_vec),
    .hit_ppn     (hit_ppn),
    .hit_perm    (hit_perm),
    .valid_vec   (valid_vec),
    .ref_vec     (ref_vec),
    .touch_en    (touch_en),
    .touch_dirty (touch_dirty),
    .flush       (flush),
    .ref_clr_all (fill_en && need_clear),
    .fill_en     (fill_en),
    .fill_idx    (vic_idx),
    .fill_vpn    (walk_vpn),
    .fill_ppn    (fill_ppn),
    .fill_perm   (fill_perm),
    .vic_idx     (vic_idx),
    .vic_valid   (vic_valid),
    .vic_dirty   (vic_dirty),
    .vic_vpn     (vic_vpn)
  );

  xc_victim_sel #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .ref_vec    (ref_vec),
    .vic_idx    (vic_idx),
    .need_clear (need_clear)
  );

  xc_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .VPN_W(VPN_W), .PA_W(PA_W)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_write       (req_write),
    .req_vaddr       (req_vaddr),
    .req_ready       (req_ready),
    .hit             (|match_vec),
    .hit_ppn         (hit_ppn),
    .hit_perm        (hit_perm),
    .fill_valid      (fill_valid),
    .fill_en         (fill_en),
    .touch_en        (touch_en),
    .touch_dirty     (touch_dirty),
    .rsp_valid       (rsp_valid),
    .rsp_hit         (rsp_hit),
    .rsp_fault       (rsp_fault),
    .rsp_miss        (rsp_miss),
    .rsp_paddr       (rsp_paddr),
    .walk_req        (walk_req),
    .walk_vpn        (walk_vpn),
    .vic_valid       (vic_valid),
    .vic_dirty       (vic_dirty),
    .vic_vpn         (vic_vpn),
    .evict_valid     (evict_valid),
    .evict_was_valid (evict_was_valid),
    .evict_dirty     (evict_dirty),
    .evict_vpn       (evict_vpn)
  );

endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_vaddr;
  logic        req_ready, rsp_valid, rsp_hit, rsp_fault, rsp_miss;
  logic [31:0] rsp_paddr;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        fill_valid, fill_rd, fill_wr, flush;
  logic [19:0] fill_ppn;
  logic        evict_valid, evict_was_valid, evict_dirty;
  logic [19:0] evict_vpn;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench-side model of the 64 entries
  bit          m_valid [64];
  bit          m_dirty [64];
  bit          m_ref   [64];
  bit          m_rd    [64];
  bit          m_wr    [64];
  logic [19:0] m_vpn   [64];
  logic [19:0] m_ppn   [64];
  logic [19:0] last_ev_vpn;
  bit          last_ev_valid;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .walk_req(walk_req), .walk_vpn(walk_vpn),
    .fill_valid(fill_valid), .fill_ppn(fill_ppn), .fill_rd(fill_rd), .fill_wr(fill_wr),
    .flush(flush),
    .evict_valid(evict_valid), .evict_was_valid(evict_was_valid),
    .evict_dirty(evict_dirty), .evict_vpn(evict_vpn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  function automatic logic [19:0] pg(int i);
    return 20'(i * 613 + 17);
  endfunction
  function automatic logic [19:0] ppn_of(logic [19:0] v);
    return v ^ 20'h5A3C1;
  endfunction
  function automatic bit rd_of(logic [19:0] v);
    return v[2:0] != 3'b111;
  endfunction
  function automatic bit wr_of(logic [19:0] v);
    return v[0];
  endfunction

  function automatic int m_find(logic [19:0] v);
    for (int i = 0; i < 64; i++) if (m_valid[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] va);
    logic [19:0] vpn;
    vpn = va[31:12];
    for (int pass = 0; pass < 2; pass++) begin
      int idx, v;
      bit ok_perm, from_inv, exp_valid, exp_dirty;
      logic [19:0] exp_vpn;
      logic [31:0] exp_pa;
      idx = m_find(vpn);
      @(negedge clk); req_valid = 1'b1; req_write = wr; req_vaddr = va;
      @(negedge clk); req_valid = 1'b0;
      check(rsp_valid == 1'b1, "R1", 64'(rsp_valid), 64'd1);
      if (idx >= 0) begin
        ok_perm = wr ? m_wr[idx] : m_rd[idx];
        check(rsp_hit == ok_perm && rsp_fault == !ok_perm && !rsp_miss, "R4",
              {61'd0, rsp_hit, rsp_fault, rsp_miss}, {61'd0, ok_perm, !ok_perm, 1'b0});
        exp_pa = ok_perm ? {m_ppn[idx], va[11:0]} : 32'd0;
        check(rsp_paddr == exp_pa, ok_perm ? "R1" : "R4", 64'(rsp_paddr), 64'(exp_pa));
        m_ref[idx] = 1'b1;
        if (wr && ok_perm) m_dirty[idx] = 1'b1;
        break;
      end
      check(rsp_miss && !rsp_hit && !rsp_fault, "R3",
            {61'd0, rsp_hit, rsp_fault, rsp_miss}, 64'd1);
      check(walk_req && !req_ready && walk_vpn == vpn, "R3",
            {42'd0, walk_req, req_ready, walk_vpn}, {42'd0, 2'b10, vpn});
      // A request offered while waiting must be ignored.
      req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
      check(!rsp_valid && walk_req && walk_vpn == vpn, "R3",
            {62'd0, rsp_valid, walk_req}, 64'd1);
      // Model victim choice
      from_inv = 1'b0;
      v = -1;
      for (int i = 0; i < 64; i++) if (!m_valid[i] && v < 0) begin v = i; from_inv = 1'b1; end
      if (v < 0) for (int i = 0; i < 64; i++) if (!m_ref[i] && v < 0) v = i;
      if (v < 0) begin
        for (int i = 0; i < 64; i++) m_ref[i] = 1'b0;
        v = 0;
      end
      exp_valid = m_valid[v];
      exp_dirty = m_dirty[v];
      exp_vpn   = m_vpn[v];
      fill_valid = 1'b1; fill_ppn = ppn_of(vpn); fill_rd = rd_of(vpn); fill_wr = wr_of(vpn);
      @(negedge clk); fill_valid = 1'b0;
      check(evict_valid && evict_was_valid == exp_valid, from_inv ? "R6" : "R7",
            {62'd0, evict_valid, evict_was_valid}, {62'd0, 1'b1, exp_valid});
      if (exp_valid) begin
        check(evict_vpn == exp_vpn, "R9", 64'(evict_vpn), 64'(exp_vpn));
        check(evict_dirty == exp_dirty, exp_dirty ? "R5" : "R9", 64'(evict_dirty), 64'(exp_dirty));
      end
      last_ev_vpn   = evict_vpn;
      last_ev_valid = evict_was_valid;
      check(req_ready && !walk_req, "R3", {62'd0, req_ready, walk_req}, 64'd2);
      m_valid[v] = 1'b1; m_dirty[v] = 1'b0; m_ref[v] = 1'b1;
      m_vpn[v] = vpn; m_ppn[v] = ppn_of(vpn); m_rd[v] = rd_of(vpn); m_wr[v] = wr_of(vpn);
      @(negedge clk);
      check(!evict_valid, "R9", 64'(evict_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 0; m_dirty[i] = 0; m_ref[i] = 0;
    end
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_vaddr = '0;
    fill_valid = 0; fill_ppn = '0; fill_rd = 0; fill_wr = 0; flush = 0;
    repeat (3) @(negedge clk);
    check(req_ready && !walk_req && !rsp_valid && !evict_valid, "R11",
          {60'd0, req_ready, walk_req, rsp_valid, evict_valid}, 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !walk_req && !rsp_valid && !evict_valid, "R11",
          {60'd0, req_ready, walk_req, rsp_valid, evict_valid}, 64'h8);

    // Fill all 64 slots with reads at varied offsets.
    for (int i = 0; i < 64; i++) begin
      access(1'b0, {pg(i), 12'(i * 67)});
      if (i == 0) check(!last_ev_valid, "R2", 64'(last_ev_valid), 64'd0);
    end
    // Writes to every cached page: dirty marks and write faults.
    for (int i = 0; i < 64; i++) access(1'b1, {pg(i), 12'h0});

    // Full with every reference flag set: the clear-all case picks slot 0.
    access(1'b0, {pg(64), 12'h123});
    check(last_ev_vpn == pg(0), "R7", 64'(last_ev_vpn), 64'(pg(0)));
    // Hits on slots 1 and 2 protect them; next victim is slot 3.
    access(1'b0, {pg(1), 12'h010});
    access(1'b1, {pg(2), 12'h020});
    access(1'b0, {pg(65), 12'h456});
    check(last_ev_vpn == pg(3), "R8", 64'(last_ev_vpn), 64'(pg(3)));

    // Further replacement under the model.
    for (int i = 66; i < 110; i++) access(i[0], {pg(i), 12'(i * 31)});

    // Offset passthrough sweep on a readable page.
    for (int k = 0; k < 16; k++) access(1'b0, {pg(65), 12'(k * 273)});

    // Flush, then a page known to be cached must miss.
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;
    access(1'b0, {pg(65), 12'h777});
    check(!last_ev_valid, "R10", 64'(last_ev_valid), 64'd0);
    for (int i = 110; i < 120; i++) access(1'b0, {pg(i), 12'h3});

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule